// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block turns the system clock into a one-cycle `bit_tick` enable that paces a classic 8-bit microcontroller serial port. The controller's machine cycle is one sixth of the system clock. The tick rate follows the selected serial mode. The shift mode runs at a fixed rate. The fixed 9-bit mode runs at a rate set by the rate-doubling bit. The two variable modes run from the overflow rate of one of two 8-bit auto-reload timers. A source select picks which timer. Both timers advance once per machine cycle.

The block works only in clock ratios, so it serves at any system clock frequency. The configuration pins are `ser_mode`, `dbl_rate` and `use_t2`. When any of them changes, every counter in the block restarts. The next tick then comes one full new period later. Reload values are taken when a timer wraps and when the block restarts. Control pins are plain levels. The single output is a strobe with no handshake, so it applies no back-pressure. A consumer that misses a strobe loses that bit slot.

Top module: `sio_baud_gen`

## Requirements
- R1: With `ser_mode` = 0, `bit_tick` pulses once every 6 clocks.
- R2: With `ser_mode` = 2, the tick period is 32 clocks when `dbl_rate` = 0 and 16 clocks when `dbl_rate` = 1.
- R3: With `ser_mode` = 1 or 3 and `use_t2` = 0, the period is 6 × (256 − `t1_reload`) × 32 clocks when `dbl_rate` = 0, and 6 × (256 − `t1_reload`) × 16 clocks when `dbl_rate` = 1.
- R4: With `ser_mode` = 1 or 3 and `use_t2` = 1, the period is 6 × (256 − `t2_reload`) × 16 clocks. `dbl_rate` does not change this period.
- R5: A timer reloads its reload value in the same machine cycle in which it counts from 0xFF. A reload of 0xFF therefore overflows on every machine cycle, and a reload of 0x00 overflows every 256 machine cycles.
- R6: A reload value takes effect at the next wrap or restart. The reload of the timer that is not selected has no effect on `bit_tick`.
- R7: A change of `ser_mode`, `dbl_rate` or `use_t2` that is sampled at a clock edge restarts all counters, and no tick follows that edge. The first tick comes exactly one new period after the edge.
- R8: `bit_tick` is never high for two clocks in a row.
- R9: Synchronous reset (`rst` = 1) holds `bit_tick` low. Ticks then come at multiples of the period, counted from the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_mode | input | 2 | Serial mode: 0 shift, 1 and 3 timer-driven, 2 fixed 9-bit |
| dbl_rate | input | 1 | Rate-doubling bit |
| use_t2 | input | 1 | 1 selects timer 2, 0 selects timer 1 for modes 1 and 3 |
| t1_reload | input | 8 | Auto-reload value for timer 1 |
| t2_reload | input | 8 | Auto-reload value for timer 2 |
| bit_tick | output | 1 | One-clock bit-period strobe |

## Verification
The collision of interest is a configuration restart that lands on the same clock edge as a due tick. The bench runs the fixed 9-bit mode at its fast rate and changes the configuration right after the clock in which the divider stands one count short of a tick. The edge that would have raised `bit_tick` is then also the restart edge. The behavioural model expects no pulse on that edge and the next pulse one full new period later, and the strobe is compared against the model on every clock.

// File: rtl/sio_brg_pkg.sv
package sio_brg_pkg;

  typedef enum logic [1:0] {
    SM_SHIFT = 2'd0,
    SM_VAR8  = 2'd1,
    SM_FIX9  = 2'd2,
    SM_VAR9  = 2'd3
  } ser_mode_e;

  typedef struct packed {
    ser_mode_e mode;
    logic      dbl;
    logic      use_t2;
  } brg_cfg_t;

endpackage

// File: rtl/sio_brg_prescale.sv
module sio_brg_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic mc_en
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || clr)      pc <= '0;
    else if (pc == LAST) pc <= '0;
    else                 pc <= pc + 1'b1;
  end

  assign mc_en = (pc == LAST);

  // machine-cycle strobe never lasts two clocks (R1)
  assert_mc_single_R1: assert property (@(posedge clk) disable iff (rst)
    mc_en |=> !mc_en);

endmodule

// File: rtl/sio_brg_timer.sv
module sio_brg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         ovf
);
  logic [W-1:0] cnt;

  assign ovf = step && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst || clr || ovf) cnt <= reload;
    else if (step)         cnt <= cnt + 1'b1;
  end

  // wrap from all-ones lands on the reload value in the same step (R5)
  assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == $past(reload)));

  // restart loads the reload value currently presented (R6)
  assert_restart_load_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == $past(reload)));

endmodule

// File: rtl/sio_brg_postdiv.sv
module sio_brg_postdiv #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ev,
  input  logic [W-1:0] last,
  output logic         fire
);
  logic [W-1:0] cnt;

  assign fire = ev && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (fire)   cnt <= '0;
    else if (ev)     cnt <= cnt + 1'b1;
  end

  // count stays within the selected terminal value (R2)
  assert_div_bound_R2: assert property (@(posedge clk) disable iff (rst || clr)
    cnt <= last);

endmodule

// File: rtl/sio_baud_gen.sv
module sio_baud_gen
  import sio_brg_pkg::*;
#(
  parameter int CLK_PER_MC = 6,
  parameter int TMR_W      = 8,
  parameter int DIV_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ser_mode,
  input  logic             dbl_rate,
  input  logic             use_t2,
  input  logic [TMR_W-1:0] t1_reload,
  input  logic [TMR_W-1:0] t2_reload,
  output logic             bit_tick
);
  localparam int NTMR = 2;
  localparam logic [DIV_W-1:0] LAST_SLOW = '1;
  localparam logic [DIV_W-1:0] LAST_FAST = {1'b0, {(DIV_W-1){1'b1}}};
  localparam logic [DIV_W-1:0] LAST_ONE  = '0;

  brg_cfg_t cfg_in, cfg_q;
  logic     clr;

  assign cfg_in = '{mode: ser_mode_e'(ser_mode), dbl: dbl_rate, use_t2: use_t2};

  always_ff @(posedge clk) cfg_q <= cfg_in;

  assign clr = (cfg_in != cfg_q);

  logic mc_en;

  sio_brg_prescale #(.DIV(CLK_PER_MC)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .mc_en (mc_en)
  );

  logic [TMR_W-1:0] rel [NTMR];
  logic [NTMR-1:0]  ovf;

  assign rel[0] = t1_reload;
  assign rel[1] = t2_reload;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    sio_brg_timer #(.W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .step   (mc_en),
      .reload (rel[g]),
      .ovf    (ovf[g])
    );
  end

  logic             ev;
  logic [DIV_W-1:0] last;
  logic             fire;

  always_comb begin
    unique case (cfg_in.mode)
      SM_SHIFT: begin
        ev   = mc_en;
        last = LAST_ONE;
      end
      SM_FIX9: begin
        ev   = 1'b1;
        last = cfg_in.dbl ? LAST_FAST : LAST_SLOW;
      end
      default: begin
        ev   = cfg_in.use_t2 ? ovf[1] : ovf[0];
        last = (cfg_in.use_t2 || cfg_in.dbl) ? LAST_FAST : LAST_SLOW;
      end
    endcase
  end

  sio_brg_postdiv #(.W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .ev   (ev),
    .last (last),
    .fire (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) bit_tick <= 1'b0;
    else     bit_tick <= fire && !clr;
  end

  assert_one_clock_R8: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> !bit_tick);

  assert_reset_low_R9: assert property (@(posedge clk)
    rst |=> !bit_tick);

  // in shift mode a tick always follows a machine-cycle strobe (R1)
  assert_shift_on_mc_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && cfg_q.mode == SM_SHIFT) |-> $past(mc_en));

endmodule

// File: tb/sio_baud_gen_tb.sv
module sio_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ser_mode = 2'd2;
  logic       dbl_rate = 1'b1;
  logic       use_t2 = 1'b0;
  logic [7:0] t1_reload = 8'h00;
  logic [7:0] t2_reload = 8'h00;
  logic       bit_tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sio_baud_gen u_dut (
    .clk       (clk),
    .rst       (rst),
    .ser_mode  (ser_mode),
    .dbl_rate  (dbl_rate),
    .use_t2    (use_t2),
    .t1_reload (t1_reload),
    .t2_reload (t2_reload),
    .bit_tick  (bit_tick)
  );

  function automatic int period(int m, bit d, bit s, int r1, int r2);
    if (m == 0)      return 6;
    else if (m == 2) return d ? 16 : 32;
    else if (s)      return 6 * (256 - r2) * 16;
    else             return 6 * (256 - r1) * (d ? 16 : 32);
  endfunction

  // behavioural reference: clocks since last restart and current period
  logic [3:0] prev_cfg = 4'hF;
  int since = 0;
  int p_cur = 6;

  always @(posedge clk) begin
    if (rst || {ser_mode, dbl_rate, use_t2} != prev_cfg) begin
      since <= 0;
      p_cur <= period(ser_mode, dbl_rate, use_t2, t1_reload, t2_reload);
    end else begin
      since <= since + 1;
    end
    prev_cfg <= {ser_mode, dbl_rate, use_t2};
  end

  always @(negedge clk) begin
    bit    exp;
    string tag;
    exp = !rst && since > 0 && (since % p_cur == 0);
    if (rst)                tag = "R9";
    else if (since == 0)    tag = "R7";
    else if (ser_mode == 0) tag = "R1";
    else if (ser_mode == 2) tag = "R2";
    else if (use_t2)        tag = "R4";
    else                    tag = "R3";
    n_cmp++;
    if (bit_tick !== exp) begin
      n_bad++;
      $display("FAIL %s cycle-compare: bit_tick=%b expected=%b (since=%0d period=%0d)",
               tag, bit_tick, exp, since, p_cur);
    end
  end

  task automatic seg(input int m, input bit d, input bit s, input int r1, input int r2,
                     input int len, input int poke, input string tag);
    int n;
    int exp_n;
    ser_mode  = m[1:0];
    dbl_rate  = d;
    use_t2    = s;
    t1_reload = r1[7:0];
    t2_reload = r2[7:0];
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (bit_tick) n++;
      if (poke != 0 && i == poke) t2_reload = ~t2_reload;
    end
    exp_n = (len - 1) / period(m, d, s, r1, r2);
    n_cmp++;
    if (n != exp_n) begin
      n_bad++;
      $display("FAIL %s window-count: ticks=%0d expected=%0d", tag, n, exp_n);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    n_cmp++;
    if (bit_tick !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset-state: bit_tick=%b expected=0", bit_tick);
    end
    rst = 1'b0;
    seg(0, 0, 0, 8'h00, 8'h00, 100, 0, "R1");
    seg(2, 0, 0, 8'h00, 8'h00, 200, 0, "R2");
    // ends one clock before a due tick: restart collides with it (R7)
    seg(2, 1, 0, 8'h00, 8'h00, 32, 0, "R7");
    seg(2, 0, 0, 8'h00, 8'h00, 64, 0, "R7");
    seg(1, 1, 0, 8'hFF, 8'h00, 500, 0, "R5");
    seg(3, 0, 0, 8'hFF, 8'h00, 600, 0, "R3");
    seg(1, 0, 1, 8'h00, 8'hFF, 500, 0, "R4");
    seg(1, 1, 1, 8'h00, 8'hFF, 300, 0, "R4");
    // unselected reload flipped mid-run (R6)
    seg(3, 1, 0, 8'hF0, 8'h33, 3200, 700, "R6");
    seg(1, 1, 0, 8'h00, 8'h00, 25000, 0, "R5");
    seg(3, 0, 0, 8'h00, 8'h00, 50000, 0, "R3");
    seg(3, 0, 1, 8'h00, 8'h00, 25000, 0, "R4");
    // reset mid-run then full period from the reset edge (R9)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seg(0, 0, 0, 8'h00, 8'h00, 60, 0, "R9");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule